// File: doc/BRIEF.md
# Serial NOR Flash Command Responder

This block is the device side of a four-wire serial link that acts like a small NOR flash. A host lowers chip select, clocks opcode, address and data bytes in on the data-in line, and reads response bytes on the data-out line. Behind the link is a byte array that is built into the block. Its size and its erase-sector size are parameters, and both are kept small for simulation. The block recognises a fixed opcode set: identification, streaming read, write enable, page program, sector erase, whole-array erase, a switch to four-byte addresses, and a two-opcode soft reset.

The serial pins are sampled by the system clock. Each pin passes through one register, and edges on the serial clock are found by comparing that register with its value on the previous cycle. Bits are taken on the rising serial-clock edge, most significant bit first. A new response bit is placed on the data-out line shortly after each rising edge, so the host reads it on the next rising edge (mode 0). The host may send several single-byte opcodes one after another inside one chip-select window. Program data goes into the array byte by byte as it arrives. Erase takes effect when chip select is released.

Top module: `nor_flash_resp`

## Requirements
- R1: Opcode 0x9F makes the block return the bytes 0x20, 0xBA and 0x19, in that order, on the three bytes that follow it. Every later byte in the same window reads 0x00.
- R2: Opcode 0x03, followed by an address sent most significant byte first, returns the byte at that address. It then returns the bytes at the following addresses for as long as chip select stays low. The address wraps from the top of the array (0x7FF at default size) to 0x000.
- R3: Program (0x02), sector erase (0xD8) and whole-array erase (0xC7) change the array only if the write-enable latch is set when the opcode is decoded. Opcode 0x06 sets the latch.
- R4: Each program data byte is ANDed into the addressed location. The address then steps forward but stays inside the current 256-byte page: offset 0xFF is followed by offset 0x00 of the same page.
- R5: Sector erase sets every byte of the sector that holds the given address to 0xFF (512-byte sectors at default size). All other sectors keep their contents. The erase is applied after chip select rises.
- R6: Whole-array erase sets every location to 0xFF once chip select rises.
- R7: Opcode 0xB7 switches address capture from three bytes to four. The setting remains in force in later windows until a reset.
- R8: Opcode 0x66 followed directly by 0x99 returns the block to three-byte addressing and clears the write-enable latch. If 0x99 arrives without 0x66 just before it, it has no effect.
- R9: The write-enable latch clears when chip select rises after a program or erase opcode was accepted. A second program in a later window, with no new 0x06, changes nothing.
- R10: The host may send several opcodes back to back in one window. Once a single-byte opcode (0x06, 0xB7, 0x66, 0x99, 0xC7) has completed, the next byte is decoded as an opcode.
- R11: An unknown opcode makes the block ignore every remaining byte until chip select goes high, including bytes that would be valid opcodes. The data-out line is held low whenever no response data is due.
- R12: Hardware reset clears the array to 0x00, selects three-byte addressing and clears the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
A rising edge on the serial clock takes effect two system clocks after the bench drives it: one cycle passes through the input register and the next cycle holds the edge-detect condition. So a new data-out bit is ready two clocks after the rising edge that moved it out, and an erase has finished two clocks after chip select goes high. The bench keeps each serial-clock phase at least three system clocks long. It reads data-out on a falling system-clock edge, just before it raises the serial clock, and it waits six clocks after chip select goes high before it starts the next window. Every array check therefore reads back through a fresh read command, after any pending erase or program has finished.

// File: rtl/nor_flash_resp.sv
module nor_flash_resp #(
  parameter int MEM_BYTES    = 2048,
  parameter int SECTOR_BYTES = 512,
  parameter int PAGE_BYTES   = 256,
  parameter logic [7:0] ID0  = 8'h20,
  parameter logic [7:0] ID1  = 8'hBA,
  parameter logic [7:0] ID2  = 8'h19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int SW = $clog2(SECTOR_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  localparam logic [7:0] OP_ID    = 8'h9F;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SECT  = 8'hD8;
  localparam logic [7:0] OP_CHIP  = 8'hC7;
  localparam logic [7:0] OP_4B    = 8'hB7;
  localparam logic [7:0] OP_RSTEN = 8'h66;
  localparam logic [7:0] OP_RST   = 8'h99;

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_READ, ST_PROG, ST_ID, ST_SKIP} st_t;
  typedef enum logic [1:0] {D_READ, D_PROG, D_SECT} dest_t;

  logic s_sck, p_sck, s_cs, p_cs, s_mosi;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh, tx_next;
  logic [AW-9:0] addr_sh;
  logic [1:0] addr_left, id_idx;
  logic [AW-1:0] ptr;
  logic [AW-SW-1:0] sect;
  logic wel, addr4, rst_armed, wr_taken, pend_chip, pend_sect;
  st_t st;
  dest_t dest;
  logic [7:0] mem [MEM_BYTES];

  wire sck_rise  = s_sck & ~p_sck & ~s_cs;
  wire cs_rise   = s_cs & ~p_cs;
  wire byte_done = sck_rise & (bit_cnt == 3'd7);
  wire [7:0] rx  = {rx_sh, s_mosi};
  wire [AW-1:0] cap_addr = {addr_sh, rx};
  wire prog_we   = byte_done & (st == ST_PROG);
  wire erase_go  = cs_rise & (pend_chip | pend_sect);
  wire do_rst    = byte_done & (st == ST_CMD) & (rx == OP_RST) & rst_armed;

  assign miso = ~s_cs & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck <= 1'b0; p_sck <= 1'b0; s_cs <= 1'b1; p_cs <= 1'b1; s_mosi <= 1'b0;
    end else begin
      s_sck <= sck; p_sck <= s_sck; s_cs <= cs_n; p_cs <= s_cs; s_mosi <= mosi;
    end
  end

  always_comb begin
    tx_next = 8'h00;
    case (st)
      ST_CMD:  if (rx == OP_ID) tx_next = ID0;
      ST_ID:   tx_next = (id_idx == 2'd0) ? ID1 : (id_idx == 2'd1) ? ID2 : 8'h00;
      ST_ADDR: if (addr_left == 2'd0 && dest == D_READ) tx_next = mem[cap_addr];
      ST_READ: tx_next = mem[ptr];
      default: tx_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD; dest <= D_READ; bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0;
      addr_sh <= '0; addr_left <= '0; id_idx <= '0; ptr <= '0; sect <= '0;
      wel <= 1'b0; addr4 <= 1'b0; rst_armed <= 1'b0; wr_taken <= 1'b0;
      pend_chip <= 1'b0; pend_sect <= 1'b0;
    end else if (s_cs) begin
      st <= ST_CMD; bit_cnt <= '0; tx_sh <= '0;
      if (cs_rise) begin
        if (wr_taken) wel <= 1'b0;
        wr_taken <= 1'b0; pend_chip <= 1'b0; pend_sect <= 1'b0;
      end
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      rx_sh <= rx[6:0];
      tx_sh <= (bit_cnt == 3'd7) ? tx_next : {tx_sh[6:0], 1'b0};
      if (byte_done) begin
        case (st)
          ST_CMD: begin
            rst_armed <= (rx == OP_RSTEN);
            case (rx)
              OP_ID:    begin st <= ST_ID; id_idx <= '0; end
              OP_WREN:  wel <= 1'b1;
              OP_4B:    addr4 <= 1'b1;
              OP_RSTEN: ;
              OP_RST:   if (rst_armed) begin
                          addr4 <= 1'b0; wel <= 1'b0; wr_taken <= 1'b0;
                          pend_chip <= 1'b0; pend_sect <= 1'b0;
                        end
              OP_READ:  begin st <= ST_ADDR; dest <= D_READ; addr_left <= addr4 ? 2'd3 : 2'd2; end
              OP_PROG:  if (wel) begin
                          st <= ST_ADDR; dest <= D_PROG; wr_taken <= 1'b1;
                          addr_left <= addr4 ? 2'd3 : 2'd2;
                        end else st <= ST_SKIP;
              OP_SECT:  if (wel) begin
                          st <= ST_ADDR; dest <= D_SECT; wr_taken <= 1'b1;
                          addr_left <= addr4 ? 2'd3 : 2'd2;
                        end else st <= ST_SKIP;
              OP_CHIP:  if (wel) begin pend_chip <= 1'b1; wr_taken <= 1'b1; end
              default:  st <= ST_SKIP;
            endcase
          end
          ST_ADDR: begin
            addr_sh <= cap_addr[AW-9:0];
            addr_left <= addr_left - 2'd1;
            if (addr_left == 2'd0) begin
              case (dest)
                D_READ:  begin ptr <= cap_addr + AW'(1); st <= ST_READ; end
                D_PROG:  begin ptr <= cap_addr; st <= ST_PROG; end
                default: begin sect <= cap_addr[AW-1:SW]; pend_sect <= 1'b1; st <= ST_SKIP; end
              endcase
            end
          end
          ST_READ: ptr <= ptr + AW'(1);
          ST_PROG: ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
          ST_ID:   if (id_idx != 2'd2) id_idx <= id_idx + 2'd1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    end else begin
      for (int i = 0; i < MEM_BYTES; i++)
        if (erase_go && (pend_chip || (AW'(i) >> SW) == AW'(sect))) mem[i] <= 8'hFF;
      if (prog_we) mem[ptr] <= mem[ptr] & rx;
    end
  end
endmodule

// File: rtl/nor_flash_resp_chk.sv
module nor_flash_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic miso,
  input logic wel,
  input logic addr4,
  input logic wr_taken,
  input logic cs_rise,
  input logic prog_we,
  input logic erase_go,
  input logic do_rst
);
  p_prog_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> wel);
  p_erase_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> wel);
  p_wel_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wr_taken) |=> !wel);
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> (!addr4 && !wel));
  p_addr4_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr4 && !do_rst) |=> addr4);
  p_miso_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !miso);
endmodule

bind nor_flash_resp nor_flash_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .wel(wel), .addr4(addr4),
  .wr_taken(wr_taken), .cs_rise(cs_rise), .prog_we(prog_we), .erase_go(erase_go),
  .do_rst(do_rst)
);

// File: tb/sim_nor_flash_resp.sv
module sim_nor_flash_resp;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] r0, r1, r2, r3, r4;

  always #10 clk = ~clk;

  nor_flash_resp u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  // {address[15:0], program data, expected readback}
  localparam logic [31:0] VEC [6] = '{
    {16'h0010, 8'hA5, 8'hA5},
    {16'h0010, 8'h3C, 8'h24},
    {16'h03FF, 8'h5A, 8'h5A},
    {16'h07FF, 8'h81, 8'h81},
    {16'h0200, 8'h0F, 8'h0F},
    {16'h0200, 8'hF1, 8'h01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = b[i];
      repeat (2) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel;
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic desel;
    @(negedge clk) cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] j;
    sel; xfer(op, j); desel;
  endtask

  task automatic rd3(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] j;
    sel; xfer(8'h03, j); xfer(8'h00, j); xfer(a[15:8], j); xfer(a[7:0], j); xfer(8'h00, d); desel;
  endtask

  task automatic rd4(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] j;
    sel; xfer(8'h03, j); xfer(8'h00, j); xfer(8'h00, j); xfer(a[15:8], j); xfer(a[7:0], j);
    xfer(8'h00, d); desel;
  endtask

  task automatic pp3(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] j;
    sel; xfer(8'h02, j); xfer(8'h00, j); xfer(a[15:8], j); xfer(a[7:0], j); xfer(d, j); desel;
  endtask

  task automatic hw_reset;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] j;
    hw_reset;

    // R12: array cleared on hardware reset; MISO low while deselected (R11)
    chk("R12 reset miso", {7'd0, miso}, 8'h00);
    rd3(16'h0000, r0); chk("R12 reset array", r0, 8'h00);

    // R1 identification, then zeros (R11)
    sel; xfer(8'h9F, j); xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3); desel;
    chk("R1 id0", r0, 8'h20); chk("R1 id1", r1, 8'hBA); chk("R1 id2", r2, 8'h19);
    chk("R1 id tail", r3, 8'h00);

    // R3: whole erase without latch does nothing
    op1(8'hC7);
    rd3(16'h0000, r0); chk("R3 erase w/o latch", r0, 8'h00);

    // R6: whole erase with latch
    op1(8'h06); op1(8'hC7);
    rd3(16'h0000, r0); chk("R6 erase low", r0, 8'hFF);
    rd3(16'h07FF, r0); chk("R6 erase high", r0, 8'hFF);

    // R3: program without latch does nothing
    pp3(16'h0040, 8'h12);
    rd3(16'h0040, r0); chk("R3 prog w/o latch", r0, 8'hFF);

    // R4: programmed bytes AND into the array
    for (int k = 0; k < 6; k++) begin
      op1(8'h06);
      pp3(VEC[k][31:16], VEC[k][15:8]);
      rd3(VEC[k][31:16], r0);
      chk("R4 table", r0, VEC[k][7:0]);
    end

    // R4: page wrap 0x1FE,0x1FF,0x100
    op1(8'h06);
    sel; xfer(8'h02, j); xfer(8'h00, j); xfer(8'h01, j); xfer(8'hFE, j);
    xfer(8'h11, j); xfer(8'h22, j); xfer(8'h33, j); desel;
    rd3(16'h01FE, r0); chk("R4 wrap 1FE", r0, 8'h11);
    rd3(16'h01FF, r0); chk("R4 wrap 1FF", r0, 8'h22);
    rd3(16'h0100, r0); chk("R4 wrap 100", r0, 8'h33);
    rd3(16'h0101, r0); chk("R4 wrap 101", r0, 8'hFF);

    // R9: latch consumed by previous program
    pp3(16'h0180, 8'h00);
    rd3(16'h0180, r0); chk("R9 latch cleared", r0, 8'hFF);

    // R2: streaming across page and across array end
    sel; xfer(8'h03, j); xfer(8'h00, j); xfer(8'h01, j); xfer(8'hFE, j);
    xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); desel;
    chk("R2 stream0", r0, 8'h11); chk("R2 stream1", r1, 8'h22); chk("R2 stream2", r2, 8'h01);
    sel; xfer(8'h03, j); xfer(8'h00, j); xfer(8'h07, j); xfer(8'hFF, j);
    xfer(8'h00, r0); xfer(8'h00, r1); desel;
    chk("R2 top", r0, 8'h81); chk("R2 wrap", r1, 8'hFF);

    // R5: sector erase of 0x200..0x3FF
    op1(8'h06);
    sel; xfer(8'hD8, j); xfer(8'h00, j); xfer(8'h02, j); xfer(8'h10, j); desel;
    rd3(16'h0200, r0); chk("R5 sector start", r0, 8'hFF);
    rd3(16'h03FF, r0); chk("R5 sector end", r0, 8'hFF);
    rd3(16'h01FF, r0); chk("R5 below kept", r0, 8'h22);
    rd3(16'h0010, r0); chk("R5 low kept", r0, 8'h24);
    rd3(16'h07FF, r0); chk("R5 above kept", r0, 8'h81);

    // R7: four-byte addressing, persistent
    op1(8'hB7);
    rd4(16'h07FF, r0); chk("R7 4-byte", r0, 8'h81);
    rd4(16'h0010, r0); chk("R7 persists", r0, 8'h24);

    // R8: lone 0x99 has no effect; 0x66 0x99 resets (with R10 packing)
    op1(8'h99);
    rd4(16'h0010, r0); chk("R8 lone 99", r0, 8'h24);
    sel; xfer(8'h06, j); xfer(8'h66, j); xfer(8'h99, j); desel;
    rd3(16'h0010, r0); chk("R8 3-byte again", r0, 8'h24);
    pp3(16'h0180, 8'h00);
    rd3(16'h0180, r0); chk("R8 latch cleared", r0, 8'hFF);

    // R10: opcodes back to back in one window
    sel; xfer(8'h06, j); xfer(8'h9F, j); xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); desel;
    chk("R10 id after wren", r0, 8'h20); chk("R10 id1", r1, 8'hBA); chk("R10 id2", r2, 8'h19);
    sel; xfer(8'h06, j); xfer(8'h02, j); xfer(8'h00, j); xfer(8'h01, j); xfer(8'h80, j);
    xfer(8'h5A, j); desel;
    rd3(16'h0180, r0); chk("R10 wren+prog", r0, 8'h5A);

    // R11: unknown opcode swallows the rest of the window
    sel; xfer(8'hAB, r0); xfer(8'h06, r1); xfer(8'hC7, r2); xfer(8'h9F, r3); xfer(8'h00, r4); desel;
    chk("R11 miso low a", r1 | r2, 8'h00); chk("R11 miso low b", r3 | r4 | r0, 8'h00);
    rd3(16'h0180, r0); chk("R11 no erase", r0, 8'h5A);
    op1(8'hC7);
    rd3(16'h0180, r0); chk("R11 wren ignored", r0, 8'h5A);

    // R12: hardware reset mid-run
    op1(8'hB7); op1(8'h06);
    hw_reset;
    rd3(16'h0180, r0); chk("R12 array zero", r0, 8'h00);
    op1(8'hC7);
    rd3(16'h0010, r0); chk("R12 latch clear", r0, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule